// File: doc/BRIEF.md
# Serial Result Capture and Two-Deep Latched History

This block turns the one-bit result stream of a bit-serial arithmetic unit into parallel bytes that a display can show. On each enabled clock the incoming result bit enters a chain of shift stages. The first stage's contents are brought out as a live byte, so a display can follow the packet while it is being assembled.

Each shift stage also has its own output latch. A single strobe, issued once per packet at a fixed bit time, copies every stage into its latch at the same edge. Between strobes the latched bytes do not move, however much shifting takes place. The bit that leaves the first stage enters the second stage, so the second stage's latch holds the result before the newest one. With the default depth of two, the history outputs give the two most recent completed results.

The depth of the history, the data width and the bit order are parameters.

Top module: `serial_result_display`

## Requirements
- R1: While `rst_n` is low, every shift stage and every latch reads zero, so `live_byte` and `hist_flat` are all zeros.
- R2: On a rising clock edge with `shift_en` high, the first stage takes `ser_in` into its top bit (bit DATA_W-1) and moves its old bits down by one place. The default order is least significant bit first, so after eight enabled edges `live_byte` holds the last eight bits, with the first of them in bit 0.
- R3: On a clock edge with `shift_en` low, no shift stage changes, whatever value `ser_in` has.
- R4: On an enabled edge, each later stage takes as its entering bit the bit that leaves the stage before it, which is that stage's bit 0 before the edge.
- R5: On a rising edge with `latch_stb` high, each latch loads the contents its stage held before that edge, even if a shift happens at the same edge. Latch k appears in `hist_flat[k*DATA_W +: DATA_W]`.
- R6: On an edge with `latch_stb` low, no latched byte changes, whatever the shift activity.
- R7: Suppose a result has been shifted in and latched into history slot 0. If eight more bits are then shifted in and a strobe follows, the older result appears in slot 1 and the newer one in slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial result bit from the arithmetic unit |
| shift_en | input | 1 | Advances all shift stages by one bit |
| latch_stb | input | 1 | Copies all shift stages into their output latches |
| live_byte | output | DATA_W | Current contents of the first shift stage |
| hist_flat | output | DEPTH*DATA_W | Latched history, where slot 0 is the newest result |

## Verification
The assertions assume that `rst_n` is held low from time zero until the first clock edges have passed. They also assume that the control inputs are settled at each rising edge, so that shift and strobe can be judged on the edge alone. The stimulus changes every input only on falling edges and keeps reset asserted for several cycles at start-up and again in the middle of the run. Within those limits it mixes random values of `ser_in`, `shift_en` and `latch_stb`, including strobes at the same edge as a shift, with directed packets whose byte values are known.

// File: rtl/serial_result_display_pkg.sv
package serial_result_display_pkg;

   // Order in which the bits of a packet arrive on the serial line
   typedef enum logic {
      ORDER_LSB_FIRST = 1'b0,
      ORDER_MSB_FIRST = 1'b1
   } bit_order_e;

   localparam int unsigned MIN_DATA_W = 2;
   localparam int unsigned MAX_DEPTH  = 16;

endpackage

// File: rtl/ser_shift_stage.sv
module ser_shift_stage
   import serial_result_display_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit_order_e  ORDER  = ORDER_LSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [DATA_W-1:0] word_q
);

   localparam int unsigned ENTRY_IDX = (ORDER == ORDER_LSB_FIRST) ? DATA_W - 1 : 0;

   logic [DATA_W-1:0] word_nxt;

   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("ser_shift_stage: DATA_W below minimum");
   end

   generate
      if (ORDER == ORDER_LSB_FIRST) begin : g_lsb_first
         always_comb word_nxt = {bit_in, word_q[DATA_W-1:1]};
      end else begin : g_msb_first
         always_comb word_nxt = {word_q[DATA_W-2:0], bit_in};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (shift_en) begin
         word_q <= word_nxt;
      end
   end

   // R1
   stage_reset_clear_chk: assert property (@(posedge clk) !rst_n |-> word_q == '0);

   // R2
   stage_entry_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> word_q[ENTRY_IDX] == $past(bit_in));

   // R3
   stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(word_q));

endmodule

// File: rtl/hold_latch.sv
module hold_latch #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

   // R1
   latch_reset_clear_chk: assert property (@(posedge clk) !rst_n |-> q == '0);

   // R5
   latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(d));

   // R6
   latch_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/serial_result_display.sv
module serial_result_display
   import serial_result_display_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 2,
   parameter bit_order_e  ORDER  = ORDER_LSB_FIRST
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ser_in,
   input  logic                    shift_en,
   input  logic                    latch_stb,
   output logic [DATA_W-1:0]       live_byte,
   output logic [DEPTH*DATA_W-1:0] hist_flat
);

   localparam int unsigned ENTRY_IDX = (ORDER == ORDER_LSB_FIRST) ? DATA_W - 1 : 0;
   localparam int unsigned EXIT_IDX  = (ORDER == ORDER_LSB_FIRST) ? 0 : DATA_W - 1;

   if (DEPTH < 1 || DEPTH > MAX_DEPTH) begin : g_bad_depth
      $error("serial_result_display: DEPTH out of range");
   end
   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("serial_result_display: DATA_W below minimum");
   end

   logic [DATA_W-1:0] stage_word [DEPTH];
   logic              chain_bit  [DEPTH];

   assign chain_bit[0] = ser_in;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         if (g > 0) begin : g_link
            assign chain_bit[g] = stage_word[g-1][EXIT_IDX];

            // R4
            chain_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
               shift_en |=> stage_word[g][ENTRY_IDX] == $past(stage_word[g-1][EXIT_IDX]));
         end

         ser_shift_stage #(
            .DATA_W (DATA_W),
            .ORDER  (ORDER)
         ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .bit_in   (chain_bit[g]),
            .word_q   (stage_word[g])
         );

         hold_latch #(
            .DATA_W (DATA_W)
         ) u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (latch_stb),
            .d     (stage_word[g]),
            .q     (hist_flat[g*DATA_W +: DATA_W])
         );
      end
   endgenerate

   assign live_byte = stage_word[0];

   // R6
   history_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_stb |=> $stable(hist_flat));

endmodule

// File: tb/serial_result_display_tb_top.sv
module serial_result_display_tb_top;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned W          = 8;
   localparam int unsigned N          = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ser_in = 1'b0;
   logic           shift_en = 1'b0;
   logic           latch_stb = 1'b0;
   logic [W-1:0]   live_byte;
   logic [N*W-1:0] hist_flat;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   bit          done = 1'b0;

   logic [W-1:0] m_sr  [N];
   logic [W-1:0] m_lat [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_result_display #(.DATA_W(W), .DEPTH(N)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_in    (ser_in),
      .shift_en  (shift_en),
      .latch_stb (latch_stb),
      .live_byte (live_byte),
      .hist_flat (hist_flat)
   );

   function automatic logic [W-1:0] shifted(logic [W-1:0] w, logic b);
      return {b, w[W-1:1]};
   endfunction

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_all();
      chk("R2", live_byte, m_sr[0]);
      chk("R5", hist_flat[W-1:0], m_lat[0]);
      chk("R4", hist_flat[2*W-1:W], m_lat[1]);
   endtask

   task automatic model_clear();
      for (int k = 0; k < N; k++) begin
         m_sr[k]  = '0;
         m_lat[k] = '0;
      end
   endtask

   // drive at falling edge, model at rising edge, compare at next falling edge
   task automatic step(logic b, logic en, logic stb);
      logic [W-1:0] old_sr [N];
      ser_in = b; shift_en = en; latch_stb = stb;
      @(posedge clk);
      for (int k = 0; k < N; k++) old_sr[k] = m_sr[k];
      if (en) begin
         m_sr[0] = shifted(old_sr[0], b);
         for (int k = 1; k < N; k++) m_sr[k] = shifted(old_sr[k], old_sr[k-1][0]);
      end
      if (stb) for (int k = 0; k < N; k++) m_lat[k] = old_sr[k];
      @(negedge clk);
      chk_all();
   endtask

   task automatic send_byte(logic [W-1:0] v);
      for (int i = 0; i < W; i++) step(v[i], 1'b1, 1'b0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] h0;
      logic [W-1:0] h1;
      void'($urandom(32'h5EED_0042));
      model_clear();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", live_byte, 8'h00);
      chk("R1", hist_flat[W-1:0], 8'h00);
      chk("R1", hist_flat[2*W-1:W], 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: byte arrives least significant bit first
      send_byte(8'hA5);
      chk("R2", live_byte, 8'hA5);

      // R3 and R6: no enable and no strobe leave everything alone
      for (int i = 0; i < 6; i++) step(1'($urandom), 1'b0, 1'b0);
      chk("R3", live_byte, 8'hA5);
      chk("R6", hist_flat[W-1:0], 8'h00);

      // R5: strobe copies the stage
      step(1'b0, 1'b0, 1'b1);
      chk("R5", hist_flat[W-1:0], 8'hA5);

      // R6: shifting without strobe keeps history
      send_byte(8'h3C);
      chk("R6", hist_flat[W-1:0], 8'hA5);
      chk("R6", hist_flat[2*W-1:W], 8'h00);

      // R7: after eight more bits and a strobe, the older result moves to slot 1
      step(1'b0, 1'b0, 1'b1);
      chk("R7", hist_flat[W-1:0], 8'h3C);
      chk("R7", hist_flat[2*W-1:W], 8'hA5);

      // R5: strobe together with a shift takes the pre-edge contents
      send_byte(8'hF0);
      h0 = live_byte;
      step(1'b1, 1'b1, 1'b1);
      chk("R5", hist_flat[W-1:0], h0);
      chk("R4", hist_flat[2*W-1:W], 8'h3C);
      chk("R2", live_byte, 8'hF8);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         step(1'($urandom), ($urandom % 4) != 0, ($urandom % 9) == 0);
      end

      // R7: two packets back to back with strobes
      send_byte(8'h81);
      step(1'b0, 1'b0, 1'b1);
      send_byte(8'h7E);
      step(1'b0, 1'b0, 1'b1);
      h0 = hist_flat[W-1:0];
      h1 = hist_flat[2*W-1:W];
      chk("R7", h0, 8'h7E);
      chk("R7", h1, 8'h81);

      // R1: reset in the middle of the run
      rst_n = 1'b0;
      model_clear();
      @(negedge clk);
      chk("R1", live_byte, 8'h00);
      chk("R1", hist_flat[W-1:0], 8'h00);
      chk("R1", hist_flat[2*W-1:W], 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      send_byte(8'h5A);
      step(1'b0, 1'b0, 1'b1);
      chk("R1", hist_flat[2*W-1:W], 8'h00);
      chk("R5", hist_flat[W-1:0], 8'h5A);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule